// File: doc/BRIEF.md
# Remote Terminal Command Validation Sequencer

This block sits between a serial word decoder and the reply logic of a serial-bus remote terminal. It sees each decoded 16-bit word as a one-cycle strobe, with a flag telling a command/status word from a data word. It decides whether a command is meant for this terminal and whether it is legal. It counts the data words that follow, and it tells the encoder when to start the status reply. It also handles the case where this terminal is the receiver of a terminal-to-terminal transfer, and it runs a watchdog on the transmitter.

The terminal's 5-bit address and its odd-parity bit come from pins. They are captured into a holding register while a latch input is high. Address 31 is the broadcast address. An external active-low veto input lets outside logic declare the current command illegal. That logic reads the command fields exposed by the block, and the block samples the veto at one fixed point after the command strobe. All delays are counted in cycles of the clock. The clock frequency (10, 12, 16 or 20 MHz) is a parameter, and the cycle counts are derived from it.

The sequencer has six states. ST_IDLE waits for a command. ST_VETO_WAIT waits out the veto window. ST_RX_DATA counts data words. ST_PEER_SYNC waits for the other terminal to start replying, and ST_PEER_STAT checks that terminal's status word. ST_REPLY_WAIT times the status reply. The transitions are:
- idle→veto-wait on an accepted command.
- veto-wait→rx-data when words are due.
- veto-wait→reply-wait or →idle when no words are due.
- rx-data→peer-sync on a valid transmit command.
- peer-sync→peer-stat on sync.
- peer-stat→rx-data on a matching status word.
- rx-data→reply-wait or →idle when the count is complete.
- reply-wait→idle when the reply starts.
- any busy state→idle on a fault.

Top module: `rt_cmd_seq`

## Requirements
- R1: While `addr_latch` is high, the address and parity pins are loaded into the holding register on each clock edge; otherwise they are held. After reset the register holds address 0 with parity 1. `addr_par_err` is high when the six held bits contain an even number of ones.
- R2: A command word is accepted when its bits [15:11] equal the held address and `addr_par_err` is low. Any other non-broadcast command is ignored, and `msg_active` stays low.
- R3: A command whose bits [15:11] are 31 is accepted whatever the held address or its parity. No `reply_start` is produced for it, and `cmd_bcast` reads 1.
- R4: `cmd_veto_n` is sampled only at the (2·CLK_MHZ+1)-th clock edge after the command strobe. If it is low there, the message ends with `msg_fault` instead of `msg_good`, and a reply is still given. Its value at any other edge has no effect.
- R5: From the strobe of an accepted command, `cmd_tr`, `cmd_sa` and `cmd_mc` show that command's bits [10], [9:5] and [4:0].
- R6: The number of data words due is defined as follows:
  - If bit 10 is 1, none are due.
  - If the subaddress is 0 or 31, one is due when mode-code bit 4 is 1, and none otherwise.
  - Otherwise the due count is the word count, where 0 means 32.
  When the last due word arrives, `msg_good` pulses once (if not vetoed).
- R7: If the next due word does not arrive within 24·CLK_MHZ cycles of the previous word, `msg_fault` pulses and no reply follows. A data word arriving during the veto window also causes a fault.
- R8: `reply_start` pulses exactly RESP_HALF_US·CLK_MHZ/2 + 1 clock edges after the strobe of the last word of a non-broadcast message. For a message with no data words, that last word is the command.
- R9: A command word that arrives as the first word after a receive command starts a terminal-to-terminal transfer only if its bit 10 is 1. Otherwise `msg_fault` pulses.
- R10: In a terminal-to-terminal transfer, `sync_det` must arrive no later than 37·CLK_MHZ/2 edges after the transmit command strobe. If it does not, `msg_fault` pulses at edge 37·CLK_MHZ/2 + 1.
- R11: In a terminal-to-terminal transfer, the other terminal's status word must carry the transmit command's address in bits [15:11]. If it does not, `msg_fault` pulses.
- R12: `tx_timeout` goes high once `tx_active` has been high for 1321·CLK_MHZ/2 consecutive edges. It clears on the first edge with `tx_active` low.
- R13: `msg_good` and `msg_fault` are never high together. `msg_active` is low out of reset and high from an accepted command until the message ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_addr | input | 5 | Terminal address pins |
| term_addr_par | input | 1 | Odd-parity bit for the address |
| addr_latch | input | 1 | Load enable of the address holding register |
| addr_par_err | output | 1 | Held address fails odd parity |
| wd_valid | input | 1 | Decoded word strobe |
| wd_cmd | input | 1 | 1: command/status sync, 0: data sync |
| wd_data | input | 16 | Decoded word |
| sync_det | input | 1 | Command/status sync seen on the bus |
| cmd_veto_n | input | 1 | Active-low illegal-command veto |
| cmd_bcast | output | 1 | Current command is broadcast |
| cmd_tr | output | 1 | Current command transmit bit |
| cmd_sa | output | 5 | Current command subaddress |
| cmd_mc | output | 5 | Current command word count / mode code |
| tx_active | input | 1 | Transmitter is driving the bus |
| tx_timeout | output | 1 | Transmitter watchdog fault |
| msg_active | output | 1 | Message in progress |
| msg_good | output | 1 | Pulse: message validated |
| msg_fault | output | 1 | Pulse: message error |
| reply_start | output | 1 | Pulse: start the status reply |

## Verification
The hardest case to reach is the receiving side of a terminal-to-terminal transfer. The bench has to give, in order: a receive command to this terminal, a transmit command with the right direction bit, a sync pulse placed at a chosen edge inside or outside the timeout, and a status word with a matching or mismatching address. Scripted tasks lay these words down on counted clock edges. The same edge counting places a one-edge veto pulse exactly on the sample point, and a veto that is low everywhere except that edge. Sweeps over every word count and every mode code, with both direction bits, compute the due count in the bench.

// File: rtl/rtv_pkg.sv
package rtv_pkg;

    localparam logic [4:0] BCAST_ADDR = 5'd31;

    // Field layout of a command word (decoded by neighbours, order fixed).
    typedef struct packed {
        logic [4:0] rta;
        logic       xmit;
        logic [4:0] sub;
        logic [4:0] cnt;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VETO_WAIT,
        ST_RX_DATA,
        ST_PEER_SYNC,
        ST_PEER_STAT,
        ST_REPLY_WAIT
    } seq_state_t;

    // Data words this terminal must receive for a command.
    function automatic logic [5:0] words_due(input cmd_word_t w);
        logic is_mode;
        is_mode = (w.sub == 5'd0) || (w.sub == 5'd31);
        if (w.xmit)
            return 6'd0;
        else if (is_mode)
            return {5'd0, w.cnt[4]};
        else if (w.cnt == 5'd0)
            return 6'd32;
        else
            return {1'b0, w.cnt};
    endfunction

endpackage

// File: rtl/rtv_addr_hold.sv
module rtv_addr_hold #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          par_in,
    input  logic          load,
    output logic [AW-1:0] addr_q,
    output logic          par_bad
);

    logic par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            par_q  <= 1'b1;
        end else if (load) begin
            addr_q <= addr_in;
            par_q  <= par_in;
        end
    end

    // Odd parity over address and parity bit.
    assign par_bad = ~(^{addr_q, par_q});

endmodule

// File: rtl/rtv_tx_watchdog.sv
module rtv_tx_watchdog #(
    parameter int LIMIT = 6605
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!active)
            run_q <= '0;
        else if (run_q != LIM)
            run_q <= run_q + 1'b1;
    end

    assign expired = (run_q == LIM);

endmodule

// File: rtl/rt_cmd_seq.sv
module rt_cmd_seq
    import rtv_pkg::*;
#(
    parameter int CLK_MHZ      = 10,
    parameter int RESP_HALF_US = 10,
    parameter int GAP_US       = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  term_addr,
    input  logic        term_addr_par,
    input  logic        addr_latch,
    output logic        addr_par_err,
    input  logic        wd_valid,
    input  logic        wd_cmd,
    input  logic [15:0] wd_data,
    input  logic        sync_det,
    input  logic        cmd_veto_n,
    output logic        cmd_bcast,
    output logic        cmd_tr,
    output logic [4:0]  cmd_sa,
    output logic [4:0]  cmd_mc,
    input  logic        tx_active,
    output logic        tx_timeout,
    output logic        msg_active,
    output logic        msg_good,
    output logic        msg_fault,
    output logic        reply_start
);

    localparam int VETO_CYC = 2 * CLK_MHZ;
    localparam int RESP_CYC = RESP_HALF_US * CLK_MHZ / 2;
    localparam int TO_CYC   = 37 * CLK_MHZ / 2;
    localparam int GAP_CYC  = GAP_US * CLK_MHZ;
    localparam int WD_CYC   = 1321 * CLK_MHZ / 2;
    localparam int TOP_A    = (GAP_CYC > TO_CYC) ? GAP_CYC : TO_CYC;
    localparam int TOP_B    = (RESP_CYC > VETO_CYC) ? RESP_CYC : VETO_CYC;
    localparam int TMR_TOP  = (TOP_A > TOP_B) ? TOP_A : TOP_B;
    localparam int TW       = $clog2(TMR_TOP + 2);
    localparam logic [TW-1:0] T_VETO = TW'(VETO_CYC);
    localparam logic [TW-1:0] T_RESP = TW'(RESP_CYC);
    localparam logic [TW-1:0] T_TO   = TW'(TO_CYC);
    localparam logic [TW-1:0] T_GAP  = TW'(GAP_CYC);
    localparam logic [TW-1:0] T_SAT  = TW'(TMR_TOP + 1);

    // ---------------- sub-units ----------------
    logic [4:0] own_addr;

    rtv_addr_hold #(.AW(5)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_in (term_addr),
        .par_in  (term_addr_par),
        .load    (addr_latch),
        .addr_q  (own_addr),
        .par_bad (addr_par_err)
    );

    rtv_tx_watchdog #(.LIMIT(WD_CYC)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tx_active),
        .expired (tx_timeout)
    );

    // ---------------- word decode ----------------
    cmd_word_t in_w;
    logic      cmd_fire, dat_fire, hit_own, hit_bc;

    assign in_w     = cmd_word_t'(wd_data);
    assign cmd_fire = wd_valid & wd_cmd;
    assign dat_fire = wd_valid & ~wd_cmd;
    assign hit_bc   = (in_w.rta == BCAST_ADDR);
    assign hit_own  = (in_w.rta == own_addr) & ~addr_par_err;

    // ---------------- state and datapath registers ----------------
    seq_state_t    state_q, state_d;
    cmd_word_t     cmd_q;
    logic [5:0]    due_q, got_q, got_nx;
    logic [4:0]    peer_q;
    logic          peer_mode_q, veto_q;
    logic [TW-1:0] tmr_q;
    logic          q_bcast;

    logic set_good, set_fault, set_go;
    logic ld_cmd, ld_peer, bump_cnt, mark_peer, take_veto;

    assign got_nx  = got_q + 6'd1;
    assign q_bcast = (cmd_q.rta == BCAST_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and control decisions
    always_comb begin
        state_d   = state_q;
        set_good  = 1'b0;
        set_fault = 1'b0;
        set_go    = 1'b0;
        ld_cmd    = 1'b0;
        ld_peer   = 1'b0;
        bump_cnt  = 1'b0;
        mark_peer = 1'b0;
        take_veto = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire && (hit_own || hit_bc)) begin
                    ld_cmd  = 1'b1;
                    state_d = ST_VETO_WAIT;
                end
            end
            ST_VETO_WAIT: begin
                if (wd_valid) begin
                    set_fault = 1'b1;
                    state_d   = ST_IDLE;
                end else if (tmr_q == T_VETO) begin
                    take_veto = 1'b1;
                    if (due_q == 6'd0) begin
                        set_good  = cmd_veto_n;
                        set_fault = ~cmd_veto_n;
                        state_d   = q_bcast ? ST_IDLE : ST_REPLY_WAIT;
                    end else begin
                        state_d = ST_RX_DATA;
                    end
                end
            end
            ST_RX_DATA: begin
                if (dat_fire) begin
                    bump_cnt = 1'b1;
                    if (got_nx == due_q) begin
                        set_good  = ~veto_q;
                        set_fault = veto_q;
                        state_d   = q_bcast ? ST_IDLE : ST_REPLY_WAIT;
                    end
                end else if (cmd_fire) begin
                    if ((got_q == 6'd0) && !peer_mode_q && in_w.xmit) begin
                        ld_peer = 1'b1;
                        state_d = ST_PEER_SYNC;
                    end else begin
                        set_fault = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end else if (tmr_q == T_GAP) begin
                    set_fault = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_PEER_SYNC: begin
                if (wd_valid || (tmr_q == T_TO)) begin
                    set_fault = 1'b1;
                    state_d   = ST_IDLE;
                end else if (sync_det) begin
                    state_d = ST_PEER_STAT;
                end
            end
            ST_PEER_STAT: begin
                if (cmd_fire && (in_w.rta == peer_q)) begin
                    mark_peer = 1'b1;
                    state_d   = ST_RX_DATA;
                end else if (wd_valid || (tmr_q == T_GAP)) begin
                    set_fault = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_REPLY_WAIT: begin
                if (tmr_q == T_RESP) begin
                    set_go  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            due_q       <= '0;
            got_q       <= '0;
            peer_q      <= '0;
            peer_mode_q <= 1'b0;
            veto_q      <= 1'b0;
            tmr_q       <= '0;
        end else begin
            if (wd_valid)
                tmr_q <= '0;
            else if (tmr_q != T_SAT)
                tmr_q <= tmr_q + 1'b1;
            if (ld_cmd) begin
                cmd_q       <= in_w;
                due_q       <= words_due(in_w);
                got_q       <= '0;
                peer_mode_q <= 1'b0;
                veto_q      <= 1'b0;
            end
            if (take_veto)
                veto_q <= ~cmd_veto_n;
            if (bump_cnt)
                got_q <= got_nx;
            if (ld_peer)
                peer_q <= in_w.rta;
            if (mark_peer)
                peer_mode_q <= 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_good    <= 1'b0;
            msg_fault   <= 1'b0;
            reply_start <= 1'b0;
        end else begin
            msg_good    <= set_good;
            msg_fault   <= set_fault;
            reply_start <= set_go;
        end
    end

    assign msg_active = (state_q != ST_IDLE);
    assign cmd_bcast  = q_bcast;
    assign cmd_tr     = cmd_q.xmit;
    assign cmd_sa     = cmd_q.sub;
    assign cmd_mc     = cmd_q.cnt;

endmodule

// File: rtl/rt_cmd_seq_chk.sv
module rt_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] term_addr,
    input logic       term_addr_par,
    input logic       addr_latch,
    input logic       addr_par_err,
    input logic       tx_active,
    input logic       tx_timeout,
    input logic       msg_active,
    input logic       msg_good,
    input logic       msg_fault,
    input logic       reply_start,
    input logic       cmd_bcast
);

    // R1
    par_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |=> (addr_par_err == ~(^{$past(term_addr), $past(term_addr_par)})));

    // R3
    bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_start |-> !cmd_bcast);

    // R8
    reply_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_active |=> !reply_start);

    // R12
    wd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_timeout) |-> $past(tx_active));

    // R12
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> !tx_timeout);

    // R13
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msg_good, msg_fault}));

endmodule

bind rt_cmd_seq rt_cmd_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .term_addr     (term_addr),
    .term_addr_par (term_addr_par),
    .addr_latch    (addr_latch),
    .addr_par_err  (addr_par_err),
    .tx_active     (tx_active),
    .tx_timeout    (tx_timeout),
    .msg_active    (msg_active),
    .msg_good      (msg_good),
    .msg_fault     (msg_fault),
    .reply_start   (reply_start),
    .cmd_bcast     (cmd_bcast)
);

// File: tb/tb_rt_cmd_seq.sv
`timescale 1ns/1ps
module tb_rt_cmd_seq;

    localparam int MHZ  = 10;
    localparam int VETO = 2 * MHZ;
    localparam int RESP = 10 * MHZ / 2;
    localparam int TOUT = 37 * MHZ / 2;
    localparam int GAP  = 24 * MHZ;
    localparam int WDOG = 1321 * MHZ / 2;
    localparam logic [4:0] OWN = 5'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  term_addr = OWN;
    logic        term_addr_par = 1'b1;
    logic        addr_latch = 1'b0;
    logic        addr_par_err;
    logic        wd_valid = 1'b0;
    logic        wd_cmd = 1'b0;
    logic [15:0] wd_data = '0;
    logic        sync_det = 1'b0;
    logic        cmd_veto_n = 1'b1;
    logic        cmd_bcast, cmd_tr;
    logic [4:0]  cmd_sa, cmd_mc;
    logic        tx_active = 1'b0;
    logic        tx_timeout, msg_active, msg_good, msg_fault, reply_start;

    rt_cmd_seq #(.CLK_MHZ(MHZ)) dut (
        .clk(clk), .rst_n(rst_n), .term_addr(term_addr), .term_addr_par(term_addr_par),
        .addr_latch(addr_latch), .addr_par_err(addr_par_err), .wd_valid(wd_valid),
        .wd_cmd(wd_cmd), .wd_data(wd_data), .sync_det(sync_det), .cmd_veto_n(cmd_veto_n),
        .cmd_bcast(cmd_bcast), .cmd_tr(cmd_tr), .cmd_sa(cmd_sa), .cmd_mc(cmd_mc),
        .tx_active(tx_active), .tx_timeout(tx_timeout), .msg_active(msg_active),
        .msg_good(msg_good), .msg_fault(msg_fault), .reply_start(reply_start)
    );

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    int n_good = 0, n_fault = 0, n_go = 0, go_cyc = 0, fault_cyc = 0, last_strobe = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (msg_good)  n_good++;
        if (msg_fault) begin n_fault++; fault_cyc = cyc; end
        if (reply_start) begin n_go++; go_cyc = cyc; end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [4:0] a, input logic tr,
                                       input logic [4:0] sa, input logic [4:0] wc);
        return {a, tr, sa, wc};
    endfunction

    function automatic int due(input logic tr, input logic [4:0] sa, input logic [4:0] wc);
        if (tr) return 0;
        if (sa == 0 || sa == 31) return (wc >= 16) ? 1 : 0;
        return (wc == 0) ? 32 : int'(wc);
    endfunction

    task automatic send(input logic is_cmd, input logic [15:0] w);
        @(negedge clk);
        wd_valid = 1'b1; wd_cmd = is_cmd; wd_data = w;
        @(posedge clk); #1;
        last_strobe = cyc;
        wd_valid = 1'b0; wd_cmd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic data_words(input int n);
        for (int i = 0; i < n; i++) begin
            send(1'b0, 16'(i * 7 + 1));
            wait_n(2);
        end
    endtask

    // Full message with reply check.
    task automatic msg_expect_reply(input string tag, input logic [15:0] c, input int nd);
        int g0, f0, r0;
        g0 = n_good; f0 = n_fault; r0 = n_go;
        send(1'b1, c);
        wait_n(VETO + 5);
        data_words(nd);
        wait_n(RESP + 10);
        chk({tag, " good"}, n_good - g0, 1);
        chk({tag, " fault"}, n_fault - f0, 0);
        chk({tag, " reply"}, n_go - r0, 1);
        chk({tag, " reply delay R8"}, go_cyc - last_strobe, RESP + 1);
    endtask

    initial begin
        int g0, f0, r0, s0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk("R13 reset active", msg_active, 0);
        chk("R1 reset par_err", addr_par_err, 0);
        chk("R12 reset timeout", tx_timeout, 0);
        chk("R13 reset pulses", n_good + n_fault + n_go, 0);

        // R1 exhaustive parity sweep
        addr_latch = 1'b1;
        for (int a = 0; a < 32; a++) begin
            for (int p = 0; p < 2; p++) begin
                term_addr = 5'(a); term_addr_par = 1'(p);
                wait_n(2);
                chk("R1 parity", addr_par_err, (($countones(5'(a)) + p) % 2 == 0) ? 1 : 0);
            end
        end
        term_addr = OWN; term_addr_par = 1'b1;
        wait_n(2);
        addr_latch = 1'b0;
        term_addr = 5'd9; term_addr_par = 1'b0;
        wait_n(2);
        chk("R1 held", addr_par_err, 0);

        // R2 live pins are not the address
        send(1'b1, mk(5'd9, 1'b1, 5'd3, 5'd4));
        wait_n(3);
        chk("R2 foreign ignored", msg_active, 0);

        // R2 / R5 / R8 own transmit command
        g0 = n_good;
        send(1'b1, mk(OWN, 1'b1, 5'd3, 5'd4));
        wait_n(2);
        chk("R2 own accepted", msg_active, 1);
        chk("R5 tr", cmd_tr, 1);
        chk("R5 sa", cmd_sa, 3);
        chk("R5 mc", cmd_mc, 4);
        chk("R3 bcast flag", cmd_bcast, 0);
        wait_n(RESP + 10);
        chk("R8 xmit reply delay", go_cyc - last_strobe, RESP + 1);
        chk("R6 xmit good", n_good - g0, 1);
        chk("R13 idle after", msg_active, 0);

        // R2 parity error blocks own address
        addr_latch = 1'b1; term_addr = OWN; term_addr_par = 1'b0;
        wait_n(2); addr_latch = 1'b0;
        send(1'b1, mk(OWN, 1'b1, 5'd1, 5'd1));
        wait_n(3);
        chk("R2 parity blocks", msg_active, 0);
        // R3 broadcast still accepted with bad parity
        r0 = n_go; g0 = n_good;
        send(1'b1, mk(5'd31, 1'b0, 5'd2, 5'd2));
        wait_n(2);
        chk("R3 bcast accepted", msg_active, 1);
        chk("R3 bcast flag", cmd_bcast, 1);
        wait_n(VETO + 5);
        data_words(2);
        wait_n(RESP + 20);
        chk("R3 bcast good", n_good - g0, 1);
        chk("R3 bcast no reply", n_go - r0, 0);
        addr_latch = 1'b1; term_addr = OWN; term_addr_par = 1'b1;
        wait_n(2); addr_latch = 1'b0;

        // R4 veto low for the whole window
        g0 = n_good; f0 = n_fault; r0 = n_go;
        cmd_veto_n = 1'b0;
        send(1'b1, mk(OWN, 1'b1, 5'd4, 5'd2));
        wait_n(VETO + 5);
        cmd_veto_n = 1'b1;
        wait_n(RESP);
        chk("R4 veto fault", n_fault - f0, 1);
        chk("R4 veto no good", n_good - g0, 0);
        chk("R4 veto still replies", n_go - r0, 1);

        // R4 veto low only on the sample edge
        f0 = n_fault;
        send(1'b1, mk(OWN, 1'b1, 5'd4, 5'd2));
        wait_n(VETO + 1);
        cmd_veto_n = 1'b0;
        @(posedge clk); #1;
        cmd_veto_n = 1'b1;
        wait_n(RESP);
        chk("R4 edge veto fault", n_fault - f0, 1);

        // R4 veto low everywhere except the sample edge
        g0 = n_good; f0 = n_fault;
        cmd_veto_n = 1'b0;
        send(1'b1, mk(OWN, 1'b1, 5'd4, 5'd2));
        wait_n(VETO);
        cmd_veto_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        cmd_veto_n = 1'b0;
        wait_n(RESP);
        cmd_veto_n = 1'b1;
        chk("R4 off-edge ignored good", n_good - g0, 1);
        chk("R4 off-edge ignored fault", n_fault - f0, 0);

        // R6 / R8 receive word count sweep
        for (int wc = 0; wc < 32; wc++)
            msg_expect_reply("R6 rx count", mk(OWN, 1'b0, 5'd1, 5'(wc)), due(1'b0, 5'd1, 5'(wc)));

        // R6 mode code sweep
        for (int s = 0; s < 2; s++)
            for (int tr = 0; tr < 2; tr++)
                for (int mc = 0; mc < 32; mc++)
                    msg_expect_reply("R6 mode", mk(OWN, 1'(tr), (s == 0) ? 5'd0 : 5'd31, 5'(mc)),
                                     due(1'(tr), (s == 0) ? 5'd0 : 5'd31, 5'(mc)));

        // R7 short messages
        for (int k = 0; k < 4; k++) begin
            automatic logic [4:0] wc = (k == 0) ? 5'd1 : (k == 1) ? 5'd2 : (k == 2) ? 5'd17 : 5'd0;
            g0 = n_good; f0 = n_fault; r0 = n_go;
            send(1'b1, mk(OWN, 1'b0, 5'd6, wc));
            wait_n(VETO + 5);
            data_words(due(1'b0, 5'd6, wc) - 1);
            wait_n(GAP + 10);
            chk("R7 short fault", n_fault - f0, 1);
            chk("R7 short no good", n_good - g0, 0);
            chk("R7 short no reply", n_go - r0, 0);
            chk("R7 short idle", msg_active, 0);
        end

        // R7 data word inside veto window
        f0 = n_fault;
        send(1'b1, mk(OWN, 1'b0, 5'd6, 5'd2));
        wait_n(3);
        send(1'b0, 16'h1234);
        wait_n(3);
        chk("R7 early data fault", n_fault - f0, 1);

        // R9 second command with T/R = 0
        f0 = n_fault;
        send(1'b1, mk(OWN, 1'b0, 5'd2, 5'd2));
        wait_n(VETO + 5);
        send(1'b1, mk(5'd12, 1'b0, 5'd2, 5'd2));
        wait_n(3);
        chk("R9 peer rx cmd fault", n_fault - f0, 1);

        // R10 no sync: fault at TOUT+1 edges
        f0 = n_fault;
        send(1'b1, mk(OWN, 1'b0, 5'd2, 5'd2));
        wait_n(VETO + 5);
        send(1'b1, mk(5'd12, 1'b1, 5'd2, 5'd2));
        s0 = last_strobe;
        wait_n(TOUT + 5);
        chk("R10 timeout fault", n_fault - f0, 1);
        chk("R10 timeout edge", fault_cyc - s0, TOUT + 1);

        // R10 / R11 sync on the last allowed edge, wrong status address
        f0 = n_fault;
        send(1'b1, mk(OWN, 1'b0, 5'd2, 5'd2));
        wait_n(VETO + 5);
        send(1'b1, mk(5'd12, 1'b1, 5'd2, 5'd2));
        wait_n(TOUT);
        sync_det = 1'b1;
        @(posedge clk); #1;
        sync_det = 1'b0;
        wait_n(3);
        chk("R10 late-edge sync accepted", msg_active, 1);
        chk("R10 no fault yet", n_fault - f0, 0);
        send(1'b1, mk(5'd13, 1'b0, 5'd0, 5'd0));
        wait_n(3);
        chk("R11 wrong status fault", n_fault - f0, 1);

        // R9 / R11 full terminal-to-terminal receive
        g0 = n_good; f0 = n_fault; r0 = n_go;
        send(1'b1, mk(OWN, 1'b0, 5'd2, 5'd3));
        wait_n(VETO + 5);
        send(1'b1, mk(5'd12, 1'b1, 5'd2, 5'd3));
        wait_n(10);
        sync_det = 1'b1;
        @(posedge clk); #1;
        sync_det = 1'b0;
        wait_n(5);
        send(1'b1, mk(5'd12, 1'b0, 5'd0, 5'd0));
        wait_n(3);
        data_words(3);
        wait_n(RESP + 10);
        chk("R11 peer good", n_good - g0, 1);
        chk("R9 peer fault", n_fault - f0, 0);
        chk("R8 peer reply delay", go_cyc - last_strobe, RESP + 1);
        chk("R11 peer reply", n_go - r0, 1);

        // R12 watchdog
        @(negedge clk); tx_active = 1'b1;
        wait_n(WDOG - 10);
        tx_active = 1'b0;
        wait_n(1);
        tx_active = 1'b1;
        wait_n(WDOG - 1);
        chk("R12 before limit", tx_timeout, 0);
        wait_n(1);
        chk("R12 at limit", tx_timeout, 1);
        tx_active = 1'b0;
        wait_n(1);
        chk("R12 cleared", tx_timeout, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule